// File: doc/BRIEF.md
# Oldest-First Lane Bandwidth Arbiter

Several lanes share one physical link, and only one flit can cross the link per clock. This block decides, every cycle, which lane gets that slot. A lane can compete only when two things are true: a flit is waiting in it, and the far end has buffer space for that flit. Among the lanes that can compete, the default policy picks the lane whose packet carries the earliest deadline. Each lane supplies its own deadline stamp, so traffic classes with tighter service can be favoured by giving them earlier stamps. A mode pin swaps this policy for a plain rotating order.

Deadline stamps are free-running unsigned counters that wrap. Each stamp is compared through its signed distance from a supplied current time, so the order stays correct across a wrap as long as every live stamp is within half the counter range of the current time. The decision is registered. The grant appears as a one-hot vector, a lane number and a valid flag on the clock edge after the inputs are sampled. The grant has no ready input. Back-pressure from the link reaches the block only through the per-lane space bits: a lane without space is never granted.

Top module: `vc_oldest_arb`

## Requirements
- R1: A lane is granted only if its ready bit and its space bit were both 1 in the sampled cycle. A lane with only one of them set is never granted.
- R2: With `arb_mode` = 0 (deadline mode), the grant goes to the eligible lane with the smallest signed value of (deadline − `now_ts`), taken modulo 2^TS_W. This is the eligible lane with the earliest deadline.
- R3: The deadline order is correct when stamps or `now_ts` have wrapped past zero. This holds when every stamp is within 2^(TS_W−1) of `now_ts`.
- R4: In deadline mode, when eligible lanes share the earliest deadline, the lane with the lowest index wins.
- R5: When no lane is eligible, `gnt_valid` is 0, `gnt_vec` is all zeros and `gnt_idx` is 0.
- R6: `gnt_vec` has at most one bit set. When `gnt_valid` is 1, the set bit is bit number `gnt_idx`.
- R7: With `arb_mode` = 1 (rotating mode), the grant goes to the first eligible lane found by searching upward from the rotation pointer and wrapping from the top lane to lane 0.
- R8: After a grant in rotating mode, the pointer becomes the granted lane plus one, wrapping to 0 after the top lane. In a cycle with no grant, or with a grant in deadline mode, the pointer keeps its value.
- R9: Outputs are registered. The grant for inputs sampled at a clock edge appears right after that edge and does not change before it.
- R10: While reset is asserted and right after it is released, there is no grant and the rotation pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_mode | input | 1 | 0 = earliest deadline first, 1 = rotating |
| now_ts | input | TS_W | Current time stamp |
| lane_ready | input | NUM_LANES | Lane has a flit waiting |
| lane_credit | input | NUM_LANES | Receiver has space for that lane's flit |
| lane_deadline | input | NUM_LANES*TS_W | Per-lane deadline stamps; lane i at bits [i*TS_W +: TS_W] |
| gnt_valid | output | 1 | A lane holds the slot this cycle |
| gnt_vec | output | NUM_LANES | One-hot grant |
| gnt_idx | output | clog2(NUM_LANES) | Number of the granted lane |

## Verification
Every grant output is due exactly one rising edge after the inputs it depends on were sampled. The rotation pointer also changes on that same edge, so in rotating mode a steady request pattern produces a new grant each cycle. The bench changes inputs on falling edges and reads outputs 1 ns after the next rising edge. One check also reads the outputs before that edge, to confirm they still show the previous decision. The rotation sequences are checked cycle by cycle against a pointer that the bench tracks itself.

// File: rtl/vca_pkg.sv
package vca_pkg;

  typedef enum logic {
    ARB_OLDEST = 1'b0,
    ARB_ROTATE = 1'b1
  } arb_mode_e;

endpackage

// File: rtl/vca_lane_elig.sv
module vca_lane_elig #(
  parameter int NUM_LANES = 4
) (
  input  logic [NUM_LANES-1:0] lane_ready,
  input  logic [NUM_LANES-1:0] lane_credit,
  output logic [NUM_LANES-1:0] elig
);

  // A lane competes only with a flit waiting and space at the far end.
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign elig[g] = lane_ready[g] & lane_credit[g];
  end

endmodule

// File: rtl/vca_oldest_pick.sv
module vca_oldest_pick #(
  parameter int NUM_LANES = 4,
  parameter int TS_W      = 16,
  parameter int IDX_W     = $clog2(NUM_LANES)
) (
  input  logic [NUM_LANES-1:0]      elig,
  input  logic [TS_W-1:0]           now_ts,
  input  logic [NUM_LANES*TS_W-1:0] lane_deadline,
  output logic                      found,
  output logic [IDX_W-1:0]          idx
);

  // Distance of each stamp from now; read as signed, so it is safe across a wrap.
  logic [TS_W-1:0] rel [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_rel
    assign rel[g] = lane_deadline[g*TS_W +: TS_W] - now_ts;
  end

  logic [TS_W-1:0] best;

  // Linear scan with a strict less-than, so equal stamps keep the lower index.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (elig[i] && (!found || ($signed(rel[i]) < $signed(best)))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = rel[i];
      end
    end
  end

endmodule

// File: rtl/vca_rr_pick.sv
module vca_rr_pick #(
  parameter int NUM_LANES = 4,
  parameter int IDX_W     = $clog2(NUM_LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] elig,
  input  logic                 adv,
  input  logic [IDX_W-1:0]     adv_idx,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);

  logic [IDX_W-1:0]       ptr;
  logic [2*NUM_LANES-1:0] dbl;
  logic [IDX_W-1:0]       off;
  logic [IDX_W:0]         sum;

  // Rotate the request vector so that the pointer lane lands at bit 0.
  always_comb begin
    dbl   = {elig, elig} >> ptr;
    found = 1'b0;
    off   = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (!found && dbl[k]) begin
        found = 1'b1;
        off   = IDX_W'(k);
      end
    end
    sum = {1'b0, ptr} + {1'b0, off};
    if (sum >= (IDX_W+1)'(NUM_LANES)) sum = sum - (IDX_W+1)'(NUM_LANES);
    idx = sum[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (adv_idx == IDX_W'(NUM_LANES-1)) ? '0 : adv_idx + 1'b1;
    end
  end

  // R8: the pointer holds through any cycle without a rotating grant
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));

endmodule

// File: rtl/vc_oldest_arb.sv
module vc_oldest_arb
  import vca_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int TS_W      = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         arb_mode,
  input  logic [TS_W-1:0]              now_ts,
  input  logic [NUM_LANES-1:0]         lane_ready,
  input  logic [NUM_LANES-1:0]         lane_credit,
  input  logic [NUM_LANES*TS_W-1:0]    lane_deadline,
  output logic                         gnt_valid,
  output logic [NUM_LANES-1:0]         gnt_vec,
  output logic [$clog2(NUM_LANES)-1:0] gnt_idx
);

  localparam int IDX_W = $clog2(NUM_LANES);

  logic [NUM_LANES-1:0] elig;
  logic                 old_found, rr_found, pick_found, rr_adv;
  logic [IDX_W-1:0]     old_idx, rr_idx, pick_idx;
  logic [NUM_LANES-1:0] next_vec;
  arb_mode_e            mode;

  assign mode = arb_mode_e'(arb_mode);

  vca_lane_elig #(.NUM_LANES(NUM_LANES)) u_elig (
    .lane_ready  (lane_ready),
    .lane_credit (lane_credit),
    .elig        (elig)
  );

  vca_oldest_pick #(.NUM_LANES(NUM_LANES), .TS_W(TS_W), .IDX_W(IDX_W)) u_oldest (
    .elig          (elig),
    .now_ts        (now_ts),
    .lane_deadline (lane_deadline),
    .found         (old_found),
    .idx           (old_idx)
  );

  vca_rr_pick #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig    (elig),
    .adv     (rr_adv),
    .adv_idx (rr_idx),
    .found   (rr_found),
    .idx     (rr_idx)
  );

  always_comb begin
    if (mode == ARB_ROTATE) begin
      pick_found = rr_found;
      pick_idx   = rr_idx;
    end else begin
      pick_found = old_found;
      pick_idx   = old_idx;
    end
  end

  assign rr_adv = rr_found && (mode == ARB_ROTATE);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_dec
    assign next_vec[g] = pick_found && (pick_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_vec   <= '0;
      gnt_idx   <= '0;
    end else begin
      gnt_valid <= pick_found;
      gnt_vec   <= next_vec;
      gnt_idx   <= pick_found ? pick_idx : '0;
    end
  end

  // R6: never more than one lane on the link
  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec));

  // R6: the lane number matches the one-hot bit
  p_idx_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> gnt_vec[gnt_idx]);

  // R1: the granted lane had both a flit and space in the sampled cycle
  p_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (($past(lane_ready & lane_credit) & gnt_vec) != '0));

  // R5: nothing eligible gives an empty grant
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lane_ready & lane_credit) == '0) |-> (!gnt_valid && gnt_vec == '0));

endmodule

// File: tb/tb_vc_oldest_arb.sv
module tb_vc_oldest_arb;

  localparam int N  = 4;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arb_mode = 1'b0;
  logic [TW-1:0] now_ts = '0;
  logic [N-1:0]  lane_ready = '0;
  logic [N-1:0]  lane_credit = '0;
  logic [N*TW-1:0] lane_deadline = '0;
  logic          gnt_valid;
  logic [N-1:0]  gnt_vec;
  logic [1:0]    gnt_idx;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  vc_oldest_arb #(.NUM_LANES(N), .TS_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode), .now_ts(now_ts),
    .lane_ready(lane_ready), .lane_credit(lane_credit),
    .lane_deadline(lane_deadline),
    .gnt_valid(gnt_valid), .gnt_vec(gnt_vec), .gnt_idx(gnt_idx)
  );

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: got %0d cycles exp <= 20000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  function automatic logic [N*TW-1:0] pack(input logic [TW-1:0] d0, d1, d2, d3);
    return {d3, d2, d1, d0};
  endfunction

  task automatic drive(input logic m, input logic [TW-1:0] now,
                       input logic [N-1:0] rdy, input logic [N-1:0] crd,
                       input logic [N*TW-1:0] dl);
    @(negedge clk);
    arb_mode = m; now_ts = now; lane_ready = rdy; lane_credit = crd; lane_deadline = dl;
  endtask

  // Wait for the registered result and compare it.
  task automatic expect_grant(input logic v, input logic [1:0] idx, input string tag);
    logic [N-1:0] ev;
    @(posedge clk); #1;
    ev = v ? (4'b0001 << idx) : 4'b0000;
    checks++;
    if (gnt_valid !== v || (v && gnt_idx !== idx) || (!v && gnt_idx !== 2'd0)) begin
      fails++;
      $display("FAIL %s: got valid=%0b idx=%0d exp valid=%0b idx=%0d", tag, gnt_valid, gnt_idx, v, idx);
    end
    checks++;
    if (gnt_vec !== ev) begin
      fails++;
      $display("FAIL R6 (%s): got vec=%b exp vec=%b", tag, gnt_vec, ev);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lane_ready = '0; lane_credit = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_r10();
    @(negedge clk);
    rst_n = 1'b0;
    lane_ready = '1; lane_credit = '1;
    @(posedge clk); #1;
    checks++;
    if (gnt_valid !== 1'b0 || gnt_vec !== 4'b0000) begin
      fails++;
      $display("FAIL R10: got valid=%0b vec=%b exp valid=0 vec=0000", gnt_valid, gnt_vec);
    end
    @(negedge clk);
    lane_ready = '0; lane_credit = '0;
    rst_n = 1'b1;
    // First rotating grant after reset starts at lane 0
    drive(1'b1, 16'd0, 4'b1111, 4'b1111, pack(16'd9, 16'd1, 16'd2, 16'd3));
    expect_grant(1'b1, 2'd0, "R10 pointer starts at 0");
  endtask

  task automatic t_eligibility_r1();
    do_reset();
    drive(1'b0, 16'd100, 4'b0011, 4'b0110, pack(16'd10, 16'd50, 16'd5, 16'd5));
    expect_grant(1'b1, 2'd1, "R1 only lane1 has both");
    drive(1'b0, 16'd100, 4'b0101, 4'b1010, pack(16'd10, 16'd50, 16'd5, 16'd5));
    expect_grant(1'b0, 2'd0, "R1 ready and space on different lanes");
  endtask

  task automatic t_idle_r5();
    drive(1'b0, 16'd7, 4'b0000, 4'b1111, pack(16'd1, 16'd2, 16'd3, 16'd4));
    expect_grant(1'b0, 2'd0, "R5 nothing eligible");
    drive(1'b1, 16'd7, 4'b0000, 4'b0000, pack(16'd1, 16'd2, 16'd3, 16'd4));
    expect_grant(1'b0, 2'd0, "R5 nothing eligible in rotating mode");
  endtask

  task automatic t_oldest_r2();
    drive(1'b0, 16'd1000, 4'b1111, 4'b1111, pack(16'd900, 16'd500, 16'd700, 16'd950));
    expect_grant(1'b1, 2'd1, "R2 earliest is lane1");
    drive(1'b0, 16'd1000, 4'b1101, 4'b1111, pack(16'd900, 16'd500, 16'd700, 16'd950));
    expect_grant(1'b1, 2'd2, "R2 lane1 not ready, lane2 next oldest");
    drive(1'b0, 16'd1000, 4'b1111, 4'b1001, pack(16'd900, 16'd500, 16'd700, 16'd950));
    expect_grant(1'b1, 2'd0, "R2 only lanes 0 and 3 have space");
  endtask

  task automatic t_wrap_r3();
    drive(1'b0, 16'h0010, 4'b0111, 4'b0111, pack(16'h0005, 16'hFFF0, 16'h0008, 16'h0000));
    expect_grant(1'b1, 2'd1, "R3 stamp before wrap is oldest");
    drive(1'b0, 16'hFFF0, 4'b1001, 4'b1001, pack(16'h0005, 16'h0000, 16'h0000, 16'hFFE0));
    expect_grant(1'b1, 2'd3, "R3 stamp past wrap is later");
  endtask

  task automatic t_tie_r4();
    drive(1'b0, 16'd500, 4'b1110, 4'b1111, pack(16'd100, 16'd300, 16'd300, 16'd300));
    expect_grant(1'b1, 2'd1, "R4 tie goes to lowest lane");
    drive(1'b0, 16'd500, 4'b1111, 4'b1111, pack(16'd400, 16'd450, 16'd200, 16'd200));
    expect_grant(1'b1, 2'd2, "R4 tie between lanes 2 and 3");
  endtask

  task automatic t_rotate_r7_r8();
    logic [N*TW-1:0] dl;
    dl = pack(16'd1, 16'd2, 16'd3, 16'd4);
    do_reset();
    for (int k = 0; k < 5; k++) begin
      drive(1'b1, 16'd10, 4'b1111, 4'b1111, dl);
      expect_grant(1'b1, 2'(k % 4), "R7 full rotation");
    end
    // pointer now 1
    drive(1'b1, 16'd10, 4'b0101, 4'b1111, dl);
    expect_grant(1'b1, 2'd2, "R7 search upward from pointer");
    drive(1'b1, 16'd10, 4'b0101, 4'b1111, dl);
    expect_grant(1'b1, 2'd0, "R7 wrap to lane0");
    drive(1'b1, 16'd10, 4'b0101, 4'b1111, dl);
    expect_grant(1'b1, 2'd2, "R8 pointer one past lane0");
    // pointer now 3; idle and deadline-mode grants must not move it
    drive(1'b1, 16'd10, 4'b0000, 4'b1111, dl);
    expect_grant(1'b0, 2'd0, "R8 idle cycle");
    drive(1'b0, 16'd10, 4'b1111, 4'b1111, dl);
    expect_grant(1'b1, 2'd0, "R8 deadline-mode grant");
    drive(1'b1, 16'd10, 4'b1111, 4'b1111, dl);
    expect_grant(1'b1, 2'd3, "R8 pointer held at 3");
    drive(1'b1, 16'd10, 4'b1111, 4'b1111, dl);
    expect_grant(1'b1, 2'd0, "R8 wrap after top lane");
  endtask

  task automatic t_latency_r9();
    drive(1'b0, 16'd20, 4'b0000, 4'b0000, pack(16'd1, 16'd2, 16'd3, 16'd4));
    expect_grant(1'b0, 2'd0, "R9 idle before");
    drive(1'b0, 16'd20, 4'b0100, 4'b0100, pack(16'd1, 16'd2, 16'd3, 16'd4));
    #1;
    checks++;
    if (gnt_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9: got valid=%0b before edge exp valid=0", gnt_valid);
    end
    expect_grant(1'b1, 2'd2, "R9 grant after edge");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_r10();
    t_eligibility_r1();
    t_idle_r5();
    t_oldest_r2();
    t_wrap_r3();
    t_tie_r4();
    t_rotate_r7_r8();
    t_latency_r9();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule